// File: doc/BRIEF.md
# Audio Ring Buffer Watermark Tracker

This block keeps the bookkeeping for a single audio channel whose samples live in a circular region of memory. It holds the region's first and last byte address, a read pointer and a write pointer. A data mover reports each transfer with a strobe and a byte count. In playback mode the read pointer advances. In capture mode the write pointer advances.

Each pointer has an extra wrap-phase flag in its top bit. Only the bits below it form the byte address. An empty ring has identical pointers. A full ring has matching addresses but opposite phases.

From the pointers the block derives the fill level. Playback compares free space against a programmable watermark, and capture compares the fill level against it. The first time the watermark is strictly exceeded while the channel is armed, a status bit is latched and the channel disarms. A strobe asking for more bytes than the ring can supply (playback) or hold (capture) is refused and latches an xrun status bit. Each status bit drives an interrupt output unless it is masked. Software talks to the block through a simple register write port and a combinational read port.

Top module: `audio_ring_tracker`

## Requirements
- R1: Reset has the following effects:
  - Both pointers read 0 and status reads 0.
  - The mask register (offset 5) reads 3, so both interrupt outputs are low.
  - The channel is disarmed, so a satisfied watermark condition sets no status until a rearm write.
- R2: Register offsets, written on the clock edge where `reg_we` is high:
  - 0 is the first byte address and 1 is the last byte address.
  - 2 is the read pointer and 3 is the write pointer.
  - 4 is the watermark and 5 is the mask (bit 0 mark, bit 1 xrun).
  - 9 is the mode (bit 0: 1 = capture, 0 = playback).
  - A written value reads back from the next cycle on.
  - The low 8 bits of the watermark always read as 0.
- R3: An accepted strobe advances the read pointer (playback) or write pointer (capture) by `adv_bytes`. If the sum passes the last byte address, the address wraps by the ring size and bit 31 toggles.
- R4: Offset 11 reads the fill level, as follows:
  - It is 0 when the pointers are equal.
  - It is the ring size when the addresses match and bit 31 differs.
  - Otherwise it is (write address − read address) modulo the ring size.
- R5: In playback mode, status bit 0 sets on the cycle after an armed channel's free space (size − level) is strictly greater than the watermark. Equality sets nothing.
- R6: In capture mode, status bit 0 sets on the cycle after an armed channel's fill level is strictly greater than the watermark.
- R7: A watermark event disarms the channel. Once that status bit is cleared it stays clear until bit 0 is written to the rearm register (offset 8).
- R8: Status updates regardless of the mask. The interrupt outputs are `irq_mark` = status[0] AND NOT mask[0], and `irq_xrun` = status[1] AND NOT mask[1].
- R9: Writing to offset 7 clears exactly the status bits written as 1. Offset 6 reads the status.
- R10: Offset 10 reads the position: the low 31 bits of the read pointer (playback) or write pointer (capture), minus the first byte address.
- R11: Some strobes are refused and set status bit 1, and the pointers do not move:
  - a playback strobe whose byte count exceeds the fill level;
  - a capture strobe whose byte count exceeds the free space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 4 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| adv_valid | input | 1 | Transfer strobe from the data mover |
| adv_bytes | input | 17 | Bytes moved by this transfer |
| irq_mark | output | 1 | Watermark interrupt |
| irq_xrun | output | 1 | Underflow/overflow interrupt |

## Verification
A wrong pointer or phase bit shows at once in the fill-level and position reads, so the bench sweeps pointer pairs and both phases in both modes. It compares those reads against modular arithmetic. A wrong armed flag or comparison shows one cycle after the pointers change, as a status bit that appears or fails to appear. The bench therefore probes watermark equality, strict excess, clearing without rearm, and rearm. A refused or mis-wrapped strobe shows in the next cycle's pointer readback and xrun status.

// File: rtl/art_pkg.sv
package art_pkg;
  // register offsets
  localparam logic [3:0] OFF_BASE  = 4'd0;
  localparam logic [3:0] OFF_LAST  = 4'd1;
  localparam logic [3:0] OFF_RD    = 4'd2;
  localparam logic [3:0] OFF_WR    = 4'd3;
  localparam logic [3:0] OFF_MARK  = 4'd4;
  localparam logic [3:0] OFF_MASK  = 4'd5;
  localparam logic [3:0] OFF_STAT  = 4'd6;
  localparam logic [3:0] OFF_CLR   = 4'd7;
  localparam logic [3:0] OFF_REARM = 4'd8;
  localparam logic [3:0] OFF_MODE  = 4'd9;
  localparam logic [3:0] OFF_POS   = 4'd10;
  localparam logic [3:0] OFF_LEVEL = 4'd11;
  // status bit positions
  localparam int ST_MARK = 0;
  localparam int ST_XRUN = 1;
endpackage

// File: rtl/art_ptr.sv
module art_ptr #(
  parameter int PTR_W = 32,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_val,
  input  logic             adv_en,
  input  logic [CNT_W-1:0] adv_bytes,
  input  logic [PTR_W-2:0] last_a,
  input  logic [PTR_W-1:0] size,
  output logic [PTR_W-1:0] ptr
);
  localparam int AW = PTR_W - 1;

  logic [AW:0]    sum;
  logic [AW:0]    wrapped;
  logic [PTR_W-1:0] nxt;

  always_comb begin
    sum     = {1'b0, ptr[AW-1:0]} + (AW+1)'(adv_bytes);
    wrapped = sum - size;
    nxt     = ptr;
    if (sum > {1'b0, last_a}) begin
      nxt[AW-1:0] = wrapped[AW-1:0];
      nxt[AW]     = ~ptr[AW];
    end else begin
      nxt[AW-1:0] = sum[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         ptr <= '0;
    else if (wr_en)  ptr <= wr_val;
    else if (adv_en) ptr <= nxt;
  end

  // R3: a nonzero advance moves the address backwards exactly when the phase toggles
  wrap_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && adv_en && adv_bytes != '0) |=>
      ((ptr[AW-1:0] <= $past(ptr[AW-1:0])) == (ptr[AW] != $past(ptr[AW]))));
endmodule

// File: rtl/art_events.sv
module art_events (
  input  logic       clk,
  input  logic       rst,
  input  logic       mark_hit,
  input  logic       rearm_wr,
  input  logic       xrun_evt,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic [1:0] mask,
  output logic [1:0] status,
  output logic       armed,
  output logic       irq_mark,
  output logic       irq_xrun
);
  import art_pkg::*;

  logic mark_evt;
  assign mark_evt = armed & mark_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      armed  <= 1'b0;
    end else begin
      if (rearm_wr)      armed <= 1'b1;
      else if (mark_evt) armed <= 1'b0;
      status[ST_MARK] <= mark_evt | (status[ST_MARK] & ~(clr_wr & clr_bits[ST_MARK]));
      status[ST_XRUN] <= xrun_evt | (status[ST_XRUN] & ~(clr_wr & clr_bits[ST_XRUN]));
    end
  end

  assign irq_mark = status[ST_MARK] & ~mask[ST_MARK];
  assign irq_xrun = status[ST_XRUN] & ~mask[ST_XRUN];

  // R5
  mark_latch_chk: assert property (@(posedge clk) disable iff (rst)
    mark_evt |=> status[ST_MARK]);
  // R7
  mark_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_evt && !rearm_wr) |=> !armed);
  // R7
  no_fire_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_MARK]) |-> $past(armed));
  // R9
  xrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_bits[ST_XRUN] && !xrun_evt) |=> !status[ST_XRUN]);
  // R11
  xrun_latch_chk: assert property (@(posedge clk) disable iff (rst)
    xrun_evt |=> status[ST_XRUN]);
endmodule

// File: rtl/audio_ring_tracker.sv
module audio_ring_tracker
  import art_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int CNT_W    = 17,
  parameter int MARK_LSB = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [3:0]       reg_waddr,
  input  logic [PTR_W-1:0] reg_wdata,
  input  logic [3:0]       reg_raddr,
  output logic [PTR_W-1:0] reg_rdata,
  input  logic             adv_valid,
  input  logic [CNT_W-1:0] adv_bytes,
  output logic             irq_mark,
  output logic             irq_xrun
);
  localparam int AW = PTR_W - 1;

  logic [AW-1:0] base_a, last_a, mark_q;
  logic [1:0]    mask_q;
  logic          cap_mode;
  logic [1:0][PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] rd_ptr, wr_ptr, cur_ptr;
  logic [AW:0]   size_w, level_w, free_w, room_w, bytes_x, mark_x;
  logic [AW-1:0] pos_w;
  logic          adv_ok, xrun_evt, mark_hit, rearm_wr, clr_wr;
  logic [1:0]    status;
  logic          armed;

  // fill level from the two pointers; the phase bit separates empty from full
  function automatic logic [AW:0] ring_level(input logic [PTR_W-1:0] rp,
                                             input logic [PTR_W-1:0] wp,
                                             input logic [AW:0]      sz);
    logic [AW:0] ra, wa;
    ra = {1'b0, rp[AW-1:0]};
    wa = {1'b0, wp[AW-1:0]};
    if (ra == wa)      return (rp[AW] != wp[AW]) ? sz : '0;
    else if (wa > ra)  return wa - ra;
    else               return wa + sz - ra;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a   <= '0;
      last_a   <= '0;
      mark_q   <= '0;
      mask_q   <= 2'b11;
      cap_mode <= 1'b0;
    end else if (reg_we) begin
      case (reg_waddr)
        OFF_BASE: base_a   <= reg_wdata[AW-1:0];
        OFF_LAST: last_a   <= reg_wdata[AW-1:0];
        OFF_MARK: mark_q   <= {reg_wdata[AW-1:MARK_LSB], {MARK_LSB{1'b0}}};
        OFF_MASK: mask_q   <= reg_wdata[1:0];
        OFF_MODE: cap_mode <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  assign rd_ptr  = ptr_q[0];
  assign wr_ptr  = ptr_q[1];
  assign size_w  = {1'b0, last_a} - {1'b0, base_a} + 1'b1;
  assign level_w = ring_level(rd_ptr, wr_ptr, size_w);
  assign free_w  = size_w - level_w;
  assign bytes_x = (AW+1)'(adv_bytes);
  assign mark_x  = {1'b0, mark_q};
  assign room_w  = cap_mode ? free_w : level_w;
  assign adv_ok  = bytes_x <= room_w;
  assign xrun_evt = adv_valid & ~adv_ok;
  assign mark_hit = cap_mode ? (level_w > mark_x) : (free_w > mark_x);
  assign cur_ptr  = cap_mode ? wr_ptr : rd_ptr;
  assign pos_w    = cur_ptr[AW-1:0] - base_a;
  assign rearm_wr = reg_we & (reg_waddr == OFF_REARM) & reg_wdata[0];
  assign clr_wr   = reg_we & (reg_waddr == OFF_CLR);

  for (genvar i = 0; i < 2; i++) begin : g_ptr
    localparam logic [3:0] MY_OFF = (i == 0) ? OFF_RD : OFF_WR;
    localparam logic       IS_WR  = (i == 1);
    art_ptr #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_we && reg_waddr == MY_OFF),
      .wr_val    (reg_wdata),
      .adv_en    (adv_valid && adv_ok && (cap_mode == IS_WR)),
      .adv_bytes (adv_bytes),
      .last_a    (last_a),
      .size      (size_w),
      .ptr       (ptr_q[i])
    );
  end

  art_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .mark_hit (mark_hit),
    .rearm_wr (rearm_wr),
    .xrun_evt (xrun_evt),
    .clr_wr   (clr_wr),
    .clr_bits (reg_wdata[1:0]),
    .mask     (mask_q),
    .status   (status),
    .armed    (armed),
    .irq_mark (irq_mark),
    .irq_xrun (irq_xrun)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      OFF_BASE:  reg_rdata = PTR_W'(base_a);
      OFF_LAST:  reg_rdata = PTR_W'(last_a);
      OFF_RD:    reg_rdata = rd_ptr;
      OFF_WR:    reg_rdata = wr_ptr;
      OFF_MARK:  reg_rdata = PTR_W'(mark_q);
      OFF_MASK:  reg_rdata = PTR_W'(mask_q);
      OFF_STAT:  reg_rdata = PTR_W'(status);
      OFF_MODE:  reg_rdata = PTR_W'(cap_mode);
      OFF_POS:   reg_rdata = PTR_W'(pos_w);
      OFF_LEVEL: reg_rdata = PTR_W'(level_w);
      default:   reg_rdata = '0;
    endcase
  end

  // R11
  refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_valid && !adv_ok && !reg_we) |=> ($stable(rd_ptr) && $stable(wr_ptr)));
  // R3
  idle_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv_valid && !reg_we) |=> ($stable(rd_ptr) && $stable(wr_ptr)));
endmodule

// File: tb/audio_ring_tracker_test.sv
module audio_ring_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        adv_valid = 1'b0;
  logic [16:0] adv_bytes = '0;
  logic        irq_mark, irq_xrun;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] LAST = 32'h4FF;
  localparam int          SIZE = 32'h400;

  always #2 clk = ~clk;

  audio_ring_tracker uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .adv_valid(adv_valid), .adv_bytes(adv_bytes),
    .irq_mark(irq_mark), .irq_xrun(irq_xrun));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic adv(input int n);
    @(negedge clk);
    adv_valid = 1'b1; adv_bytes = 17'(n);
    @(negedge clk);
    adv_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_raddr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic int exp_level(input logic [31:0] rp, input logic [31:0] wp);
    int ra, wa;
    ra = int'(rp[30:0]) - int'(BASE);
    wa = int'(wp[30:0]) - int'(BASE);
    if (ra == wa) return (rp[31] == wp[31]) ? 0 : SIZE;
    return (wa - ra + SIZE) % SIZE;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rchk("R1 rd ptr", 4'd2, 32'h0);
    rchk("R1 wr ptr", 4'd3, 32'h0);
    rchk("R1 status", 4'd6, 32'h0);
    rchk("R1 mask", 4'd5, 32'h3);
    chk("R1 irq_mark", {31'b0, irq_mark}, 32'h0);
    chk("R1 irq_xrun", {31'b0, irq_xrun}, 32'h0);

    // R2 config and readback
    wreg(4'd0, BASE);
    wreg(4'd1, LAST);
    rchk("R2 base", 4'd0, BASE);
    rchk("R2 last", 4'd1, LAST);
    wreg(4'd4, 32'h1FF);
    rchk("R2 mark low bits", 4'd4, 32'h100);
    wreg(4'd2, BASE);
    wreg(4'd3, BASE);
    tick();
    // R1 disarmed: empty playback ring has free 0x400 > mark, yet nothing latches
    rchk("R1 disarmed", 4'd6, 32'h0);

    // R4 / R10 sweep of pointer pairs, phases and modes
    for (int m = 0; m < 2; m++) begin
      wreg(4'd9, 32'(m));
      for (int ro = 0; ro < 8; ro++)
        for (int wo = 0; wo < 8; wo++)
          for (int ph = 0; ph < 2; ph++) begin
            logic [31:0] rp, wp;
            rp = BASE + 32'(ro * 32'h80);
            wp = {ph[0], 31'(BASE + 32'(wo * 32'h80))};
            wreg(4'd2, rp);
            wreg(4'd3, wp);
            rchk("R4 level", 4'd11, 32'(exp_level(rp, wp)));
            rchk("R10 position", 4'd10, (m == 1) ? 32'(wo * 32'h80) : 32'(ro * 32'h80));
            rchk("R2 wr ptr", 4'd3, wp);
          end
    end

    // playback watermark
    wreg(4'd9, 32'h0);
    wreg(4'd2, 32'h100);
    wreg(4'd3, 32'h80000100);
    wreg(4'd7, 32'h3);
    wreg(4'd8, 32'h1);
    tick();
    rchk("R5 full ring no event", 4'd6, 32'h0);
    adv(32'h100);
    tick();
    rchk("R5 free equals mark", 4'd6, 32'h0);
    rchk("R3 playback rd moved", 4'd2, 32'h200);
    adv(32'h10);
    tick();
    rchk("R5 free exceeds mark", 4'd6, 32'h1);
    chk("R8 masked irq_mark", {31'b0, irq_mark}, 32'h0);
    wreg(4'd5, 32'h2);
    chk("R8 unmasked irq_mark", {31'b0, irq_mark}, 32'h1);
    wreg(4'd7, 32'h1);
    tick();
    rchk("R7 stays clear while disarmed", 4'd6, 32'h0);
    chk("R8 irq_mark after clear", {31'b0, irq_mark}, 32'h0);
    wreg(4'd8, 32'h1);
    tick();
    rchk("R7 rearm refires", 4'd6, 32'h1);
    adv(32'h300);
    tick();
    rchk("R11 underflow status", 4'd6, 32'h3);
    rchk("R11 rd unchanged", 4'd2, 32'h210);
    chk("R8 masked irq_xrun", {31'b0, irq_xrun}, 32'h0);
    wreg(4'd5, 32'h0);
    chk("R8 unmasked irq_xrun", {31'b0, irq_xrun}, 32'h1);

    // R3 wrap past the last byte
    wreg(4'd7, 32'h3);
    wreg(4'd2, 32'h4F0);
    wreg(4'd3, 32'h80000200);
    rchk("R4 wrapped level", 4'd11, 32'h110);
    adv(32'h20);
    rchk("R3 wrap toggles phase", 4'd2, 32'h80000110);
    rchk("R4 level after wrap", 4'd11, 32'hF0);
    wreg(4'd2, 32'h800004F0);
    wreg(4'd3, 32'h00000200);
    adv(32'h10);
    rchk("R3 wrap lands on base", 4'd2, 32'h00000100);

    // capture watermark
    wreg(4'd9, 32'h1);
    wreg(4'd2, 32'h100);
    wreg(4'd3, 32'h100);
    wreg(4'd4, 32'h2FF);
    rchk("R2 mark read", 4'd4, 32'h200);
    wreg(4'd7, 32'h3);
    wreg(4'd8, 32'h1);
    tick();
    rchk("R6 empty no event", 4'd6, 32'h0);
    adv(32'h200);
    tick();
    rchk("R6 level equals mark", 4'd6, 32'h0);
    rchk("R3 capture wr moved", 4'd3, 32'h300);
    rchk("R3 capture rd held", 4'd2, 32'h100);
    adv(32'h100);
    tick();
    rchk("R6 level exceeds mark", 4'd6, 32'h1);
    rchk("R10 capture position", 4'd10, 32'h300);
    adv(32'h200);
    tick();
    rchk("R11 overflow status", 4'd6, 32'h3);
    rchk("R11 wr unchanged", 4'd3, 32'h400);
    adv(32'h100);
    rchk("R3 fill to full wraps", 4'd3, 32'h80000100);
    rchk("R4 full level", 4'd11, 32'h400);
    wreg(4'd7, 32'h2);
    tick();
    rchk("R9 clears only written bit", 4'd6, 32'h1);

    done = 1;
    finish_run();
  end
endmodule